// File: doc/BRIEF.md
# UART Receive Buffer with Trigger Level and Word-Time Timeout

This block is the receive side of a memory-mapped serial port, sitting between a deserializer and the register decoder. Each byte the deserializer delivers goes into a circular FIFO. When FIFO mode is off, it goes instead into a single holding register that the next byte overwrites. A read of the receive data register pops the oldest byte. The block keeps the receive status word, the FIFO status word and a clear-on-read error word, and it raises two sticky requests: one for receive data and one for errors.

The receive request follows a trigger level. That level is worked out from a three-bit field in the FIFO control register and a channel number fixed per instance. When the timeout is enabled, a countdown measured in word times (one `word_tick` pulse per word) raises the request for a trickle of bytes that never reaches the level. A line break is stored as a zero byte and flagged. The two reset bits in the FIFO control register act once and are never stored.

Top module: `uart_rx_buffer`

## Requirements
- R1: After a synchronous active-low reset, `rx_status` reads 4'b0110, `fifo_status`, `err_status`, `fifo_ctl`, `rd_data`, `req_rx`, `req_err` and `tx_flush` all read 0.
- R2: When `fifo_ctl[0]` is 1, accepted bytes are read back in arrival order, at most DEPTH are held, and a push and a pop in the same cycle both take effect and leave the count unchanged.
- R3: The trigger level is (fifo_ctl[6:4] + 1) times 32 for CHANNEL 0, times 8 for CHANNEL 1 or 4, times 2 for CHANNEL 2 or 3, and 0 for any other CHANNEL.
- R4: In FIFO mode `req_rx` is set when the count reaches the trigger level, or when the count is nonzero while the timeout is disabled. In holding mode it is set while data is ready. It stays set until `req_clr[0]` is pulsed with no new cause present.
- R5: When the timeout is enabled, each byte accepted into the FIFO reloads the countdown with `ctl_tmo_mult` word ticks, and a level-based request cancels it. On expiry, if data is ready or `ctl_tmo_any` is set, the block sets `req_rx` and `rx_status[3]`. Otherwise expiry has no effect.
- R6: `rx_status` is {timeout flag, 1, 1, data ready}: bit 2 means the transmitter is empty and bit 1 means the transmit buffer is empty, both constant here. A `tmo_clr` pulse clears bit 3.
- R7: `fifo_status[7:0]` is the FIFO count and `fifo_status[8]` is the full flag. While the FIFO is full, bits [7:0] read 0.
- R8: A byte arriving when the FIFO is full and no pop is made in the same cycle is dropped, and it sets `req_err` and `err_status[0]` (overrun). A read from an empty FIFO returns 0 and sets `req_err`.
- R9: `rx_break` stores a zero byte and sets `err_status[3]`. `rx_perr` and `rx_ferr` set `err_status[1]` and `err_status[2]` with the byte they come with. An `err_rd` pulse clears the whole word.
- R10: When `fifo_ctl[0]` is 0, each arriving byte overwrites the holding register shown on `rd_data` and sets data ready, and a `data_rd` pulse clears data ready.
- R11: In FIFO mode, data ready (`rx_status[0]`) stays 1 after a pop while bytes remain, and goes to 0 when the FIFO becomes empty.
- R12: Writing 1 to bit 1 of the FIFO control register empties the receive FIFO and clears data ready. Writing 1 to bit 2 gives a one-cycle `tx_flush` pulse. Both bits read back as 0 on `fifo_ctl`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | Deserializer byte strobe |
| rx_byte | input | 8 | Received byte |
| rx_perr | input | 1 | Parity error with this byte |
| rx_ferr | input | 1 | Framing error with this byte |
| rx_break | input | 1 | Line break detected, stores a zero byte |
| word_tick | input | 1 | One pulse per word time |
| fcr_wr | input | 1 | FIFO control register write strobe |
| fcr_wdata | input | 8 | FIFO control write data |
| ctl_wr | input | 1 | Timeout control write strobe |
| ctl_tmo_en | input | 1 | Timeout enable field |
| ctl_tmo_any | input | 1 | Timeout fires even with no data field |
| ctl_tmo_mult | input | 4 | Timeout length in word times |
| tmo_clr | input | 1 | Clear the timeout flag |
| req_clr | input | 2 | Write-1-to-clear: bit 0 receive request, bit 1 error request |
| data_rd | input | 1 | Receive data register read (pops) |
| err_rd | input | 1 | Error status read (clears) |
| rd_data | output | 8 | Receive data read value |
| rx_status | output | 4 | Receive status word |
| fifo_status | output | 9 | Full flag and count |
| err_status | output | 4 | {break, frame, parity, overrun} |
| fifo_ctl | output | 8 | FIFO control readback |
| req_rx | output | 1 | Receive data request |
| req_err | output | 1 | Error request |
| tx_flush | output | 1 | One-cycle transmit FIFO flush pulse |

## Verification
The bench builds the block with DEPTH = 8 and CHANNEL = 2. With these values the trigger level steps in twos from 2 to 16, so the field value 1 gives a level of 4 that a few bytes reach. The field value 7 gives 16, which the 8-entry FIFO can never reach. That lets the bench drive the full flag, the forced-zero count, overrun drops and the full-FIFO push-and-pop without a level request getting in the way. Timeouts of one and two word ticks show both the expiry that is gated off and the expiry that raises the request.

// File: rtl/uart_rxb_pkg.sv
// Package: shared widths and the channel-dependent trigger level function
// for the UART receive buffer. Assumes channel numbers are elaboration-time
// constants.
package uart_rxb_pkg;

    localparam int BYTE_W = 8;
    localparam int TRIG_W = 9;

    // Trigger level: (field + 1) scaled by a per-channel factor.
    function automatic logic [TRIG_W-1:0] rx_trig_level(input int unsigned chan,
                                                        input logic [2:0] fld);
        logic [TRIG_W-1:0] steps;
        steps = {6'd0, fld} + 9'd1;
        case (chan)
            0:       return steps << 5;
            1, 4:    return steps << 3;
            2, 3:    return steps << 1;
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/rxb_fifo.sv
// Circular byte store with power-of-two pointers and an occupancy counter.
// Assumes DEPTH is a power of two of at least 2 and the caller never pushes
// into a full store without popping in the same cycle. Flush wins over all.
module rxb_fifo #(
    parameter  int DEPTH = 16,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic          pop,
    input  logic [7:0]    wdata,
    output logic [7:0]    head,
    output logic [CW-1:0] count,
    output logic [CW-1:0] count_nxt,
    output logic          full,
    output logic          empty
);

    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;

    // Next occupancy from this cycle's push, pop and flush.
    always_comb begin
        if (flush) begin
            count_nxt = '0;
        end else begin
            case ({push, pop})
                2'b10:   count_nxt = count + CW'(1);
                2'b01:   count_nxt = count - CW'(1);
                default: count_nxt = count;
            endcase
        end
    end

    // Pointer and occupancy registers.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + AW'(1);
            if (pop)  rd_ptr <= rd_ptr + AW'(1);
            count <= count_nxt;
        end
    end

    // Byte storage, written at the store pointer.
    always_ff @(posedge clk) begin
        if (push && !flush) mem[wr_ptr] <= wdata;
    end

    assign head  = mem[rd_ptr];
    assign full  = (count == CW'(DEPTH));
    assign empty = (count == '0);

endmodule

// File: rtl/rxb_timer.sv
// Receive timeout countdown in word-time ticks. Assumes one tick pulse per
// word. Cancel beats load, load beats a tick. Expiry is a one-cycle pulse.
module rxb_timer #(
    parameter int MULT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [MULT_W-1:0] mult,
    input  logic              cancel,
    input  logic              tick,
    output logic              expire
);

    logic              run_q;
    logic [MULT_W-1:0] cnt_q;

    // Expiry pulse on the tick that ends the last word of the window.
    assign expire = run_q && tick && (cnt_q <= MULT_W'(1)) && !cancel && !load;

    // Countdown state.
    always_ff @(posedge clk) begin
        if (!rst_n || cancel) begin
            run_q <= 1'b0;
            cnt_q <= '0;
        end else if (load) begin
            run_q <= 1'b1;
            cnt_q <= mult;
        end else if (run_q && tick) begin
            if (cnt_q <= MULT_W'(1)) run_q <= 1'b0;
            else                     cnt_q <= cnt_q - MULT_W'(1);
        end
    end

endmodule

// File: rtl/uart_rx_buffer.sv
// UART receive buffer: FIFO or single holding register, trigger-level and
// timeout-driven receive request, error capture, and status words.
// Assumes DEPTH is a power of two from 2 to 128 and CHANNEL is fixed per
// instance. Register decode lives outside; this block sees strobes only.
module uart_rx_buffer #(
    parameter int DEPTH   = 16,
    parameter int CHANNEL = 0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_valid,
    input  logic [7:0] rx_byte,
    input  logic       rx_perr,
    input  logic       rx_ferr,
    input  logic       rx_break,
    input  logic       word_tick,
    input  logic       fcr_wr,
    input  logic [7:0] fcr_wdata,
    input  logic       ctl_wr,
    input  logic       ctl_tmo_en,
    input  logic       ctl_tmo_any,
    input  logic [3:0] ctl_tmo_mult,
    input  logic       tmo_clr,
    input  logic [1:0] req_clr,
    input  logic       data_rd,
    input  logic       err_rd,
    output logic [7:0] rd_data,
    output logic [3:0] rx_status,
    output logic [8:0] fifo_status,
    output logic [3:0] err_status,
    output logic [7:0] fifo_ctl,
    output logic       req_rx,
    output logic       req_err,
    output logic       tx_flush
);
    import uart_rxb_pkg::*;

    localparam int CW = $clog2(DEPTH + 1);

    logic [7:0]        fcr_q;
    logic              tmo_en_q;
    logic              tmo_any_q;
    logic [3:0]        tmo_mult_q;
    logic [7:0]        hold_q;
    logic              rdy_q;
    logic              rdy_nxt;
    logic              tmo_flag_q;
    logic [3:0]        err_q;
    logic              req_rx_q;
    logic              req_err_q;
    logic              tx_flush_q;

    logic              fifo_en;
    logic              rx_flush;
    logic              arrive;
    logic [7:0]        in_byte;
    logic              pop_ok;
    logic              acc;
    logic              drop;
    logic              rd_empty;
    logic              lvl_hit;
    logic              tmo_fire;
    logic              tmo_expire;
    logic [TRIG_W-1:0] trig;

    logic [7:0]        f_head;
    logic [CW-1:0]     f_count;
    logic [CW-1:0]     f_count_nxt;
    logic              f_full;
    logic              f_empty;

    // Input qualification: which byte arrives and whether it is kept.
    always_comb begin
        fifo_en  = fcr_q[0];
        rx_flush = fcr_wr && fcr_wdata[1];
        arrive   = rx_valid || rx_break;
        in_byte  = rx_break ? 8'h00 : rx_byte;
        pop_ok   = data_rd && fifo_en && !f_empty && !rx_flush;
        acc      = fifo_en && arrive && !rx_flush && (!f_full || pop_ok);
        drop     = fifo_en && arrive && !rx_flush && f_full && !pop_ok;
        rd_empty = data_rd && fifo_en && f_empty;
    end

    rxb_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (rx_flush),
        .push      (acc),
        .pop       (pop_ok),
        .wdata     (in_byte),
        .head      (f_head),
        .count     (f_count),
        .count_nxt (f_count_nxt),
        .full      (f_full),
        .empty     (f_empty)
    );

    // Level condition judged on the occupancy after this cycle's updates.
    always_comb begin
        trig    = rx_trig_level(CHANNEL, fcr_q[6:4]);
        lvl_hit = fifo_en &&
                  (((f_count_nxt != '0) && !tmo_en_q) ||
                   (TRIG_W'(f_count_nxt) >= trig));
    end

    rxb_timer #(.MULT_W(4)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (acc && tmo_en_q),
        .mult   (tmo_mult_q),
        .cancel (lvl_hit || rx_flush || !tmo_en_q),
        .tick   (word_tick),
        .expire (tmo_expire)
    );

    assign tmo_fire = tmo_expire && (rdy_q || tmo_any_q);

    // Data-ready next state: occupancy in FIFO mode, holding flag otherwise.
    always_comb begin
        if (fifo_en) begin
            rdy_nxt = (f_count_nxt != '0);
        end else if (arrive) begin
            rdy_nxt = 1'b1;
        end else if (data_rd || rx_flush) begin
            rdy_nxt = 1'b0;
        end else begin
            rdy_nxt = rdy_q;
        end
    end

    // Control registers; the FIFO reset bits are never stored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fcr_q      <= '0;
            tmo_en_q   <= 1'b0;
            tmo_any_q  <= 1'b0;
            tmo_mult_q <= '0;
            tx_flush_q <= 1'b0;
        end else begin
            if (fcr_wr) fcr_q <= fcr_wdata & 8'hF9;
            if (ctl_wr) begin
                tmo_en_q   <= ctl_tmo_en;
                tmo_any_q  <= ctl_tmo_any;
                tmo_mult_q <= ctl_tmo_mult;
            end
            tx_flush_q <= fcr_wr && fcr_wdata[2];
        end
    end

    // Holding register and data-ready flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
            rdy_q  <= 1'b0;
        end else begin
            if (arrive && !fifo_en) hold_q <= in_byte;
            rdy_q <= rdy_nxt;
        end
    end

    // Sticky requests, timeout flag and error word; a new cause beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_rx_q   <= 1'b0;
            req_err_q  <= 1'b0;
            tmo_flag_q <= 1'b0;
            err_q      <= '0;
        end else begin
            req_rx_q   <= (req_rx_q && !req_clr[0]) || lvl_hit ||
                          (!fifo_en && rdy_nxt) || tmo_fire;
            req_err_q  <= (req_err_q && !req_clr[1]) || drop || rd_empty;
            tmo_flag_q <= (tmo_flag_q && !tmo_clr) || tmo_fire;
            err_q      <= (err_rd ? 4'b0000 : err_q) |
                          {rx_break,
                           rx_valid && !rx_break && rx_ferr,
                           rx_valid && !rx_break && rx_perr,
                           drop};
        end
    end

    // Register read views.
    always_comb begin
        if (fifo_en) rd_data = f_empty ? 8'h00 : f_head;
        else         rd_data = hold_q;
        rx_status   = {tmo_flag_q, 1'b1, 1'b1, rdy_q};
        fifo_status = {f_full, f_full ? 8'h00 : 8'(f_count)};
        err_status  = err_q;
        fifo_ctl    = fcr_q;
        req_rx      = req_rx_q;
        req_err     = req_err_q;
        tx_flush    = tx_flush_q;
    end

endmodule

// File: rtl/uart_rx_buffer_chk.sv
// Assertion checker for uart_rx_buffer, attached by bind. Observes ports only.
module uart_rx_buffer_chk #(
    parameter int DEPTH = 16
) (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_valid,
    input logic [7:0] rx_byte,
    input logic       rx_break,
    input logic       fcr_wr,
    input logic [7:0] fcr_wdata,
    input logic       data_rd,
    input logic       err_rd,
    input logic [7:0] rd_data,
    input logic [3:0] rx_status,
    input logic [8:0] fifo_status,
    input logic [3:0] err_status,
    input logic [7:0] fifo_ctl,
    input logic       req_rx,
    input logic       req_err
);

    // R2: occupancy never exceeds the depth.
    assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, fifo_status[7:0]} <= 9'(DEPTH));

    // R2: a push and a pop together leave the status unchanged.
    assert_push_pop_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_ctl[0] && rx_valid && data_rd && !fcr_wr &&
         (fifo_status[8] || fifo_status[7:0] != 8'd0)) |=> $stable(fifo_status));

    // R12: a receive reset leaves the FIFO empty and data ready low.
    assert_rx_reset_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (fcr_wr && fcr_wdata[1] && !rx_valid && !rx_break) |=>
        (fifo_status == 9'd0 && !rx_status[0]));

    // R8: reading an empty FIFO returns zero.
    assert_empty_read_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_ctl[0] && data_rd && fifo_status == 9'd0) |-> rd_data == 8'h00);

    // R8: reading an empty FIFO raises the error request.
    assert_empty_read_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_ctl[0] && data_rd && fifo_status == 9'd0) |=> req_err);

    // R9: error status clears on read when nothing new arrives.
    assert_err_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (err_rd && !rx_valid && !rx_break) |=> err_status == 4'd0);

    // R10: holding mode shows the latest byte and data ready.
    assert_hold_latest_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_ctl[0] && !fcr_wr && rx_valid && !rx_break) |=>
        (rx_status[0] && rd_data == $past(rx_byte)));

    // R5: the timeout flag never rises without the receive request.
    assert_tmo_sets_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_status[3]) |-> req_rx);

    // R11: popping with more than one byte left keeps data ready.
    assert_ready_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_ctl[0] && data_rd && !fcr_wr &&
         (fifo_status[8] || fifo_status[7:0] > 8'd1)) |=> rx_status[0]);

endmodule

bind uart_rx_buffer uart_rx_buffer_chk #(.DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_valid    (rx_valid),
    .rx_byte     (rx_byte),
    .rx_break    (rx_break),
    .fcr_wr      (fcr_wr),
    .fcr_wdata   (fcr_wdata),
    .data_rd     (data_rd),
    .err_rd      (err_rd),
    .rd_data     (rd_data),
    .rx_status   (rx_status),
    .fifo_status (fifo_status),
    .err_status  (err_status),
    .fifo_ctl    (fifo_ctl),
    .req_rx      (req_rx),
    .req_err     (req_err)
);

// File: tb/tb_uart_rx_buffer.sv
`timescale 1ns/1ps
module tb_uart_rx_buffer;

    localparam int DEPTH   = 8;
    localparam int CHANNEL = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = '0;
    logic       rx_perr = 1'b0;
    logic       rx_ferr = 1'b0;
    logic       rx_break = 1'b0;
    logic       word_tick = 1'b0;
    logic       fcr_wr = 1'b0;
    logic [7:0] fcr_wdata = '0;
    logic       ctl_wr = 1'b0;
    logic       ctl_tmo_en = 1'b0;
    logic       ctl_tmo_any = 1'b0;
    logic [3:0] ctl_tmo_mult = '0;
    logic       tmo_clr = 1'b0;
    logic [1:0] req_clr = '0;
    logic       data_rd = 1'b0;
    logic       err_rd = 1'b0;
    logic [7:0] rd_data;
    logic [3:0] rx_status;
    logic [8:0] fifo_status;
    logic [3:0] err_status;
    logic [7:0] fifo_ctl;
    logic       req_rx;
    logic       req_err;
    logic       tx_flush;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;
    bit mon_en  = 0;
    int mcnt    = 0;
    logic [7:0] exp_q[$];

    always #2 clk = ~clk;

    uart_rx_buffer #(.DEPTH(DEPTH), .CHANNEL(CHANNEL)) dut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_break(rx_break),
        .word_tick(word_tick), .fcr_wr(fcr_wr), .fcr_wdata(fcr_wdata),
        .ctl_wr(ctl_wr), .ctl_tmo_en(ctl_tmo_en), .ctl_tmo_any(ctl_tmo_any),
        .ctl_tmo_mult(ctl_tmo_mult), .tmo_clr(tmo_clr), .req_clr(req_clr),
        .data_rd(data_rd), .err_rd(err_rd), .rd_data(rd_data),
        .rx_status(rx_status), .fifo_status(fifo_status),
        .err_status(err_status), .fifo_ctl(fifo_ctl), .req_rx(req_rx),
        .req_err(req_err), .tx_flush(tx_flush)
    );

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic idle();
        @(posedge clk); #1;
    endtask

    // Driver: deliver one byte; in FIFO mode record it if there is room.
    task automatic send(input logic [7:0] b, input logic pe, input logic fe);
        idle(); rx_valid = 1'b1; rx_byte = b; rx_perr = pe; rx_ferr = fe;
        idle(); rx_valid = 1'b0; rx_perr = 1'b0; rx_ferr = 1'b0;
        if (mon_en && mcnt < DEPTH) begin exp_q.push_back(b); mcnt++; end
    endtask

    task automatic send_break();
        idle(); rx_break = 1'b1;
        idle(); rx_break = 1'b0;
        if (mon_en && mcnt < DEPTH) begin exp_q.push_back(8'h00); mcnt++; end
    endtask

    task automatic rd();
        idle(); data_rd = 1'b1;
        idle(); data_rd = 1'b0;
        if (mon_en && mcnt > 0) mcnt--;
    endtask

    task automatic push_pop(input logic [7:0] b);
        idle(); data_rd = 1'b1; rx_valid = 1'b1; rx_byte = b;
        idle(); data_rd = 1'b0; rx_valid = 1'b0;
        exp_q.push_back(b);
    endtask

    task automatic wr_fcr(input logic [7:0] v);
        idle(); fcr_wr = 1'b1; fcr_wdata = v;
        idle(); fcr_wr = 1'b0;
    endtask

    task automatic wr_ctl(input logic en, input logic any, input logic [3:0] m);
        idle(); ctl_wr = 1'b1; ctl_tmo_en = en; ctl_tmo_any = any; ctl_tmo_mult = m;
        idle(); ctl_wr = 1'b0;
    endtask

    task automatic tick();
        idle(); word_tick = 1'b1;
        idle(); word_tick = 1'b0;
    endtask

    task automatic clr_req(input logic [1:0] m);
        idle(); req_clr = m;
        idle(); req_clr = 2'b00;
    endtask

    // Monitor: every FIFO-mode read is compared with the scoreboard head.
    always @(negedge clk) begin
        if (rst_n && mon_en && data_rd) begin
            logic [7:0] e;
            e = (exp_q.size() > 0) ? exp_q.pop_front() : 8'h00;
            check("R2/R8 read data in order", 32'(rd_data), 32'(e));
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++; n_tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) idle();
        rst_n = 1'b1;
        idle();
        // R1 reset state
        check("R1 rx_status", 32'(rx_status), 32'h6);
        check("R1 fifo_status", 32'(fifo_status), 0);
        check("R1 err_status", 32'(err_status), 0);
        check("R1 fifo_ctl", 32'(fifo_ctl), 0);
        check("R1 requests", 32'({req_rx, req_err, tx_flush}), 0);
        check("R1 rd_data", 32'(rd_data), 0);

        // R4: timeout disabled, one byte raises request
        wr_fcr(8'h01); mon_en = 1;
        send(8'hA5, 0, 0);
        check("R4 req on nonzero count", 32'(req_rx), 1);
        check("R7 count one", 32'(fifo_status), 32'h001);
        check("R11 ready set", 32'(rx_status[0]), 1);
        rd();
        check("R11 ready cleared when empty", 32'(rx_status[0]), 0);
        clr_req(2'b01);
        check("R4 request cleared", 32'(req_rx), 0);

        // R3: field 1 on channel 2 gives level 4; timeout on, 2 words
        wr_fcr(8'h11); wr_ctl(1, 0, 4'd2);
        send(8'h10, 0, 0); send(8'h11, 0, 0); send(8'h12, 0, 0);
        check("R3 below level no request", 32'(req_rx), 0);
        send(8'h13, 0, 0);
        check("R3 level 4 reached", 32'(req_rx), 1);
        for (int i = 0; i < 4; i++) rd();
        clr_req(2'b01);

        // R5: two-word timeout with data present
        send(8'h21, 0, 0);
        tick();
        check("R5 no expiry after one word", 32'(req_rx), 0);
        tick();
        check("R5 expiry raises request", 32'(req_rx), 1);
        check("R5 timeout flag set", 32'(rx_status), 32'hF);
        idle(); tmo_clr = 1'b1; idle(); tmo_clr = 1'b0;
        check("R6 timeout flag cleared", 32'(rx_status), 32'h7);
        rd(); clr_req(2'b01);

        // R5: expiry with empty FIFO, with and without the any-data field
        wr_ctl(1, 0, 4'd1);
        send(8'h31, 0, 0); rd(); tick();
        check("R5 empty expiry ignored", 32'({req_rx, rx_status[3]}), 0);
        wr_ctl(1, 1, 4'd1);
        send(8'h32, 0, 0); rd(); tick();
        check("R5 empty expiry with any-data", 32'({req_rx, rx_status[3]}), 32'h3);
        idle(); tmo_clr = 1'b1; idle(); tmo_clr = 1'b0;
        clr_req(2'b01);

        // R7/R8: fill with level 16 out of reach
        wr_fcr(8'h71); wr_ctl(1, 0, 4'd15);
        for (int i = 0; i < DEPTH; i++) send(8'h40 + 8'(i), 0, 0);
        check("R7 full flag and zero count", 32'(fifo_status), 32'h100);
        send(8'h99, 0, 0);
        check("R8 overrun error request", 32'(req_err), 1);
        check("R8 overrun bit", 32'(err_status), 32'h1);
        idle(); err_rd = 1'b1; idle(); err_rd = 1'b0;
        check("R9 error word clears on read", 32'(err_status), 0);
        push_pop(8'hEE);
        check("R2 push and pop keep count", 32'(fifo_status), 32'h100);
        for (int i = 0; i < DEPTH - 1; i++) rd();
        check("R11 ready with one left", 32'(rx_status[0]), 1);
        rd();
        check("R11 ready low when drained", 32'(rx_status[0]), 0);
        clr_req(2'b11);
        rd();
        check("R8 empty read error request", 32'(req_err), 1);
        clr_req(2'b10);

        // R9: break stores zero
        send_break();
        check("R9 break bit", 32'(err_status), 32'h8);
        check("R9 zero byte stored", 32'(fifo_status), 32'h001);
        rd();
        idle(); err_rd = 1'b1; idle(); err_rd = 1'b0;

        // R12: reset bits
        send(8'h51, 0, 0); send(8'h52, 0, 0); send(8'h53, 0, 0);
        wr_fcr(8'h77);
        exp_q.delete(); mcnt = 0;
        check("R12 reset bits read zero", 32'(fifo_ctl), 32'h71);
        check("R12 fifo emptied", 32'(fifo_status), 0);
        check("R12 ready cleared", 32'(rx_status[0]), 0);
        check("R12 tx flush pulse", 32'(tx_flush), 1);
        idle();
        check("R12 tx flush one cycle", 32'(tx_flush), 0);
        clr_req(2'b11);

        // R10: holding mode
        mon_en = 0; wr_fcr(8'h00);
        send(8'h11, 0, 0); send(8'h22, 0, 0);
        check("R10 holding overwritten", 32'(rd_data), 32'h22);
        check("R10 ready set", 32'(rx_status[0]), 1);
        check("R4 holding request", 32'(req_rx), 1);
        rd();
        check("R10 read clears ready", 32'(rx_status[0]), 0);
        clr_req(2'b01);
        check("R4 holding request cleared", 32'(req_rx), 0);

        // R9: parity and framing flags
        send(8'h33, 1, 1);
        check("R9 parity and frame bits", 32'(err_status), 32'h6);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule